// File: doc/BRIEF.md
# Network Interface Status and Parity Capture Registers

This block holds the host-visible control and status word of a network interface board, plus a pair of registers that record the most recent RAM parity fault. Through the status word the host holds the board in reset, raises the attention line to the network controller, takes the transceiver out of loopback, and enables interrupts. Reads of the same word also show the controller interrupt, the parity flag and the upper bits of the board RAM base.

A parity event from the RAM side latches the failing 20-bit address, a source bit and a byte-lane bit. This record is frozen until the host writes the acknowledge bit. The block's interrupt output merges the controller interrupt with the parity flag, and each is gated by its own enable.

Host access is a single-cycle register port. `reg_sel` picks the register, `reg_wr` qualifies a write, and read data is combinational from `reg_sel`. Select 0 is the status word, 1 is the parity control word, 2 is the low 16 bits of the failing address, and 3 is unused.

Top module: `nic_stat_par_regs`

## Requirements
- R1: While `rst_n` is low, all control bits and the parity flag clear. In the cycle after reset they read 0, and `brd_reset`, `chan_attn`, `on_air`, `aux_bus_en` and `big_ram` are all low.
- R2: A write with select 0 stores data bits 15, 14, 13, 12, 11, 5 and 4. A status read returns them in the same positions. Bits 10, 7 and 6 read 0. Written values of bits 9, 8 and 3..0 have no effect.
- R3: From the cycle after the write, `brd_reset` follows status bit 15, `on_air` bit 14, `aux_bus_en` bit 5 and `big_ram` bit 4. Writing 0x5800 enters the run state: on-air plus both interrupt enables.
- R4: `chan_attn` equals stored status bit 13. A write setting it followed by a write clearing it gives one pulse, lasting as long as the spacing between the two writes.
- R5: Status bits 3..0 show `ram_base_hi` and status bit 8 shows `ctl_irq_in`, both live and without delay.
- R6: Writes with select 2 or 3 have no effect. Writes with select 1 have no effect apart from bit 8. Select 3 reads 0.
- R7: A `perr_evt` with the flag clear sets the flag (status bit 9) in the next cycle. The parity control word then reads the source at bit 7, the lane at bit 6 and failing address bits 19..16 at bits 3..0. Select 2 reads address bits 15..0. Parity control bit 8 always reads 0.
- R8: While the flag is set, a further `perr_evt` changes neither the flag nor the captured source, lane or address.
- R9: A select-1 write with bit 8 set clears the flag in the next cycle. The captured fields keep their values.
- R10: An acknowledge and a `perr_evt` in the same cycle leave the flag set, holding the new event's source, lane and address.
- R11: `irq` is high exactly when (status bit 12 and `ctl_irq_in`) or (status bit 11 and the parity flag) hold. It is combinational in `ctl_irq_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 2 | Register select: 0 status, 1 parity control, 2 failing address low, 3 unused |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| ram_base_hi | input | 4 | Board RAM base address bits, reported in status bits 3..0 |
| ctl_irq_in | input | 1 | Interrupt request from the network controller |
| perr_evt | input | 1 | One-cycle RAM parity error event |
| perr_addr | input | 20 | Failing RAM address |
| perr_src | input | 1 | Source of the failing access |
| perr_lane | input | 1 | Byte lane that failed |
| brd_reset | output | 1 | Board reset, status bit 15 |
| chan_attn | output | 1 | Channel attention to the controller, status bit 13 |
| on_air | output | 1 | Out of loopback, status bit 14 |
| aux_bus_en | output | 1 | Auxiliary memory bus enable, status bit 5 |
| big_ram | output | 1 | Large RAM select, status bit 4 |
| irq | output | 1 | Merged interrupt request |

## Verification
Directed sequences come first. They cover an attention set-then-clear pair, which shows that the pulse ends on the clearing write. They also cover a full-ones status write, which separates writable bits from read-only and constant-zero bits. Parity cases include a first error, a second error with different fields while still latched, and a plain acknowledge. The last parity case is an acknowledge coinciding with a new error, which distinguishes priority to the new capture from priority to the clear. After that, seeded random traffic mixes writes to every select, random error events and a toggling controller interrupt. Each register and output is compared after each step with a bench model derived from the requirements.

// File: rtl/nsp_pkg.sv
package nsp_pkg;

    // status word bit positions
    localparam int BIT_RST  = 15;
    localparam int BIT_AIR  = 14;
    localparam int BIT_ATN  = 13;
    localparam int BIT_IEN  = 12;
    localparam int BIT_PIEN = 11;
    localparam int BIT_PFLG = 9;
    localparam int BIT_IFLG = 8;
    localparam int BIT_AUX  = 5;
    localparam int BIT_BIG  = 4;

    // parity control word bit positions
    localparam int PB_ACK  = 8;
    localparam int PB_SRC  = 7;
    localparam int PB_LANE = 6;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_PCTL = 2'd1,
        SEL_PADR = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic rst;
        logic air;
        logic atn;
        logic ien;
        logic pien;
        logic aux;
        logic big;
    } ctl_bits_t;

endpackage

// File: rtl/nsp_ctl_reg.sv
module nsp_ctl_reg
    import nsp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_stat,
    input  ctl_bits_t wbits,
    output ctl_bits_t ctl
);

    typedef struct packed {
        ctl_bits_t bits;
    } ctl_state_t;

    ctl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_stat) begin
            state_d.bits = wbits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctl = state_q.bits;

endmodule

// File: rtl/nsp_par_cap.sv
module nsp_par_cap #(
    parameter int HI_W = 4,
    parameter int LO_W = 16,
    localparam int AW = HI_W + LO_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_wr,
    input  logic          evt,
    input  logic [AW-1:0] evt_addr,
    input  logic          evt_src,
    input  logic          evt_lane,
    output logic          flag,
    output logic          cap_src,
    output logic          cap_lane,
    output logic [AW-1:0] cap_addr
);

    typedef struct packed {
        logic          flag;
        logic          src;
        logic          lane;
        logic [AW-1:0] addr;
    } cap_state_t;

    cap_state_t state_d, state_q;
    logic       take;

    always_comb begin
        state_d = state_q;
        // a fresh event is taken when nothing is held, or when the
        // held record is being released in this same cycle
        take = evt && (!state_q.flag || ack_wr);
        if (take) begin
            state_d.flag = 1'b1;
            state_d.src  = evt_src;
            state_d.lane = evt_lane;
            state_d.addr = evt_addr;
        end else if (ack_wr) begin
            state_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flag     = state_q.flag;
    assign cap_src  = state_q.src;
    assign cap_lane = state_q.lane;
    assign cap_addr = state_q.addr;

endmodule

// File: rtl/nsp_rd_mux.sv
module nsp_rd_mux
    import nsp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int HI_W   = 4,
    parameter int LO_W   = 16,
    localparam int AW = HI_W + LO_W
) (
    input  logic [1:0]        sel,
    input  ctl_bits_t         ctl,
    input  logic              flag,
    input  logic              irq_in,
    input  logic [HI_W-1:0]   base_hi,
    input  logic              cap_src,
    input  logic              cap_lane,
    input  logic [AW-1:0]     cap_addr,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(sel))
            SEL_STAT: begin
                rdata[BIT_RST]    = ctl.rst;
                rdata[BIT_AIR]    = ctl.air;
                rdata[BIT_ATN]    = ctl.atn;
                rdata[BIT_IEN]    = ctl.ien;
                rdata[BIT_PIEN]   = ctl.pien;
                rdata[BIT_PFLG]   = flag;
                rdata[BIT_IFLG]   = irq_in;
                rdata[BIT_AUX]    = ctl.aux;
                rdata[BIT_BIG]    = ctl.big;
                rdata[HI_W-1:0]   = base_hi;
            end
            SEL_PCTL: begin
                rdata[PB_SRC]     = cap_src;
                rdata[PB_LANE]    = cap_lane;
                rdata[HI_W-1:0]   = cap_addr[LO_W +: HI_W];
            end
            SEL_PADR: begin
                rdata[LO_W-1:0]   = cap_addr[LO_W-1:0];
            end
            default: rdata = '0;
        endcase
    end

    always_comb begin
        irq = (ctl.ien && irq_in) || (ctl.pien && flag);
    end

endmodule

// File: rtl/nic_stat_par_regs.sv
module nic_stat_par_regs
    import nsp_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_HI_W = 4,
    parameter int ADDR_LO_W = 16,
    localparam int AW = ADDR_HI_W + ADDR_LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [ADDR_HI_W-1:0] ram_base_hi,
    input  logic              ctl_irq_in,
    input  logic              perr_evt,
    input  logic [AW-1:0]     perr_addr,
    input  logic              perr_src,
    input  logic              perr_lane,
    output logic              brd_reset,
    output logic              chan_attn,
    output logic              on_air,
    output logic              aux_bus_en,
    output logic              big_ram,
    output logic              irq
);

    logic          stat_wr;
    logic          ack_wr;
    ctl_bits_t     wbits;
    ctl_bits_t     ctl;
    logic          perr_flag;
    logic          cap_src;
    logic          cap_lane;
    logic [AW-1:0] cap_addr;
    logic          par_int_en;
    logic          unused_wbits;

    assign stat_wr = reg_wr && (reg_sel == SEL_STAT);
    assign ack_wr  = reg_wr && (reg_sel == SEL_PCTL) && reg_wdata[PB_ACK];

    assign wbits.rst  = reg_wdata[BIT_RST];
    assign wbits.air  = reg_wdata[BIT_AIR];
    assign wbits.atn  = reg_wdata[BIT_ATN];
    assign wbits.ien  = reg_wdata[BIT_IEN];
    assign wbits.pien = reg_wdata[BIT_PIEN];
    assign wbits.aux  = reg_wdata[BIT_AUX];
    assign wbits.big  = reg_wdata[BIT_BIG];

    // data bits that no register stores
    assign unused_wbits = ^{reg_wdata[10:9], reg_wdata[7:6], reg_wdata[3:0]};

    nsp_ctl_reg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stat (stat_wr),
        .wbits   (wbits),
        .ctl     (ctl)
    );

    nsp_par_cap #(
        .HI_W (ADDR_HI_W),
        .LO_W (ADDR_LO_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_wr   (ack_wr),
        .evt      (perr_evt),
        .evt_addr (perr_addr),
        .evt_src  (perr_src),
        .evt_lane (perr_lane),
        .flag     (perr_flag),
        .cap_src  (cap_src),
        .cap_lane (cap_lane),
        .cap_addr (cap_addr)
    );

    nsp_rd_mux #(
        .DATA_W (DATA_W),
        .HI_W   (ADDR_HI_W),
        .LO_W   (ADDR_LO_W)
    ) u_rd (
        .sel      (reg_sel),
        .ctl      (ctl),
        .flag     (perr_flag),
        .irq_in   (ctl_irq_in),
        .base_hi  (ram_base_hi),
        .cap_src  (cap_src),
        .cap_lane (cap_lane),
        .cap_addr (cap_addr),
        .rdata    (reg_rdata),
        .irq      (irq)
    );

    assign par_int_en = ctl.pien;
    assign brd_reset  = ctl.rst;
    assign chan_attn  = ctl.atn;
    assign on_air     = ctl.air;
    assign aux_bus_en = ctl.aux;
    assign big_ram    = ctl.big;

endmodule

// File: rtl/nic_stat_par_regs_chk.sv
module nic_stat_par_regs_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stat_wr,
    input logic          ack_wr,
    input logic [2:0]    wdata_hi,
    input logic          perr_evt,
    input logic [AW-1:0] perr_addr,
    input logic          perr_flag,
    input logic [AW-1:0] cap_addr,
    input logic          par_int_en,
    input logic          irq,
    input logic          brd_reset,
    input logic          on_air,
    input logic          chan_attn
);

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!brd_reset && !chan_attn && !on_air && !perr_flag));

    // R3
    a_r3_reset_air_follow: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (brd_reset == $past(wdata_hi[2]) && on_air == $past(wdata_hi[1])));

    // R4
    a_r4_attn_follow: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (chan_attn == $past(wdata_hi[0])));

    // R4: attention holds between status writes
    a_r4_attn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> $stable(chan_attn));

    // R7
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_evt && !perr_flag) |=> (perr_flag && cap_addr == $past(perr_addr)));

    // R8
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_flag && !ack_wr) |=> (perr_flag && $stable(cap_addr)));

    // R9
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !perr_evt) |=> (!perr_flag && $stable(cap_addr)));

    // R10
    a_r10_ack_race: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && perr_evt) |=> (perr_flag && cap_addr == $past(perr_addr)));

    // R11
    a_r11_parity_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_flag && par_int_en) |-> irq);

endmodule

bind nic_stat_par_regs nic_stat_par_regs_chk #(
    .AW (ADDR_HI_W + ADDR_LO_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_wr    (stat_wr),
    .ack_wr     (ack_wr),
    .wdata_hi   (reg_wdata[15:13]),
    .perr_evt   (perr_evt),
    .perr_addr  (perr_addr),
    .perr_flag  (perr_flag),
    .cap_addr   (cap_addr),
    .par_int_en (par_int_en),
    .irq        (irq),
    .brd_reset  (brd_reset),
    .on_air     (on_air),
    .chan_attn  (chan_attn)
);

// File: tb/nic_stat_par_regs_tb.sv
module nic_stat_par_regs_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HI_W = 4;
    localparam int LO_W = 16;
    localparam int AW   = HI_W + LO_W;
    localparam logic [15:0] WMASK = 16'hF830;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr;
    logic [1:0]    reg_sel;
    logic [15:0]   reg_wdata;
    logic [15:0]   reg_rdata;
    logic [HI_W-1:0] ram_base_hi;
    logic          ctl_irq_in;
    logic          perr_evt;
    logic [AW-1:0] perr_addr;
    logic          perr_src;
    logic          perr_lane;
    logic          brd_reset, chan_attn, on_air, aux_bus_en, big_ram, irq;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    logic [15:0]   m_ctl;
    logic          m_flag, m_src, m_lane;
    logic [AW-1:0] m_addr;

    nic_stat_par_regs u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ram_base_hi(ram_base_hi),
        .ctl_irq_in (ctl_irq_in),
        .perr_evt   (perr_evt),
        .perr_addr  (perr_addr),
        .perr_src   (perr_src),
        .perr_lane  (perr_lane),
        .brd_reset  (brd_reset),
        .chan_attn  (chan_attn),
        .on_air     (on_air),
        .aux_bus_en (aux_bus_en),
        .big_ram    (big_ram),
        .irq        (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] exp_stat();
        return m_ctl | (16'(m_flag) << 9) | (16'(ctl_irq_in) << 8) | 16'(ram_base_hi);
    endfunction

    function automatic logic [15:0] exp_pctl();
        return (16'(m_src) << 7) | (16'(m_lane) << 6) | 16'(m_addr[AW-1:LO_W]);
    endfunction

    function automatic logic [15:0] exp_outs();
        logic ex_irq;
        ex_irq = (m_ctl[12] && ctl_irq_in) || (m_ctl[11] && m_flag);
        return {10'd0, m_ctl[15], m_ctl[13], m_ctl[14], m_ctl[5], m_ctl[4], ex_irq};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        reg_sel = 2'd0; #1;
        check(tag, "status", reg_rdata, exp_stat());
        reg_sel = 2'd1; #1;
        check(tag, "parity ctl", reg_rdata, exp_pctl());
        reg_sel = 2'd2; #1;
        check(tag, "parity addr", reg_rdata, m_addr[LO_W-1:0]);
        reg_sel = 2'd3; #1;
        check(tag, "unused sel", reg_rdata, 16'h0000);
        check(tag, "outputs", {10'd0, brd_reset, chan_attn, on_air, aux_bus_en, big_ram, irq},
              exp_outs());
    endtask

    task automatic model_step(input logic wr, input logic [1:0] sel, input logic [15:0] wd,
                              input logic evt, input logic [AW-1:0] pa,
                              input logic s, input logic l);
        logic ack;
        ack = wr && (sel == 2'd1) && wd[8];
        if (wr && sel == 2'd0) m_ctl = wd & WMASK;
        if (evt && (!m_flag || ack)) begin
            m_flag = 1'b1; m_src = s; m_lane = l; m_addr = pa;
        end else if (ack) begin
            m_flag = 1'b0;
        end
    endtask

    // drives one cycle of stimulus, called just after a falling edge
    task automatic step(input logic wr, input logic [1:0] sel, input logic [15:0] wd,
                        input logic evt, input logic [AW-1:0] pa,
                        input logic s, input logic l);
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        perr_evt = evt; perr_addr = pa; perr_src = s; perr_lane = l;
        @(posedge clk);
        model_step(wr, sel, wd, evt, pa, s, l);
        @(negedge clk);
        reg_wr = 1'b0; perr_evt = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [15:0] wd);
        step(1'b1, sel, wd, 1'b0, '0, 1'b0, 1'b0);
    endtask

    task automatic perr(input logic [AW-1:0] pa, input logic s, input logic l);
        step(1'b0, 2'd0, 16'h0, 1'b1, pa, s, l);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = 16'h0;
        ram_base_hi = 4'hA; ctl_irq_in = 1'b0;
        perr_evt = 1'b0; perr_addr = '0; perr_src = 1'b0; perr_lane = 1'b0;
        m_ctl = 16'h0; m_flag = 1'b0; m_src = 1'b0; m_lane = 1'b0; m_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R4: attention pulse spans the two writes
        wr_reg(2'd0, 16'h2000);
        check("R4", "attn high", {15'd0, chan_attn}, 16'd1);
        wr_reg(2'd0, 16'h0000);
        check("R4", "attn low", {15'd0, chan_attn}, 16'd0);

        // R2: all ones into status
        wr_reg(2'd0, 16'hFFFF);
        check_all("R2 R3 write ones");
        // R3: run state
        wr_reg(2'd0, 16'h5800);
        check_all("R3 run state");

        // R5: live base and controller interrupt
        ram_base_hi = 4'h3; ctl_irq_in = 1'b1; #1;
        check_all("R5 R11 live inputs");
        ctl_irq_in = 1'b0;

        // R7: first parity error
        perr(20'hABCDE, 1'b1, 1'b0);
        check_all("R7 capture");
        check("R11", "parity irq", {15'd0, irq}, 16'd1);
        // R8: second error ignored
        perr(20'h51234, 1'b0, 1'b1);
        check_all("R8 sticky");

        // R6: writes without ack, and to other selects, are ignored
        wr_reg(2'd1, 16'hFEFF);
        wr_reg(2'd2, 16'hFFFF);
        wr_reg(2'd3, 16'hFFFF);
        check_all("R6 ignored writes");

        // R9: acknowledge
        wr_reg(2'd1, 16'h0100);
        check_all("R9 ack");
        check("R11", "irq after ack", {15'd0, irq}, 16'd0);

        // R10: ack races a new event
        perr(20'h10001, 1'b0, 1'b0);
        step(1'b1, 2'd1, 16'h0100, 1'b1, 20'hF0F0F, 1'b1, 1'b1);
        check_all("R10 ack race");

        // R11: interrupt enable path only
        wr_reg(2'd0, 16'h1000);
        ctl_irq_in = 1'b1; #1;
        check("R11", "ctl irq", {15'd0, irq}, 16'd1);
        ctl_irq_in = 1'b0; #1;
        check("R11", "ctl irq off", {15'd0, irq}, 16'd0);

        for (int i = 0; i < 600; i++) begin
            logic          wr, evt;
            logic [1:0]    sel;
            logic [15:0]   wd;
            logic [AW-1:0] pa;
            wr  = ($urandom % 2) == 0;
            sel = 2'($urandom % 4);
            wd  = 16'($urandom);
            if (sel == 2'd1 && ($urandom % 3) != 0) wd[8] = 1'b0;
            evt = ($urandom % 4) == 0;
            pa  = AW'($urandom);
            ctl_irq_in = 1'($urandom);
            if (($urandom % 8) == 0) ram_base_hi = 4'($urandom);
            step(wr, sel, wd, evt, pa, 1'($urandom), 1'($urandom));
            check_all("R2 R7 R8 R9 R11 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule